// File: doc/BRIEF.md
# Fast-Lock Gain Controller

This block manages the temporary high-gain state of a phase-locked loop. It sits between the synthesizer's register file and the charge pump and dividers. It takes the mode fields that software programs, together with the GO bit of the feedback-divider word. From these it decides whether the pump runs at its normal current or at four times that current. It also decides whether the reference and feedback divide ratios are cut to a quarter, and how the auxiliary fast-lock pin is driven.

Three programmed bits select the behaviour. The first is a fast-lock enable. The second is a control bit that, once fast-lock is enabled, chooses between a wide-only boost and a boost that also shortens the dividers. The third is a timeout enable. In the timed modes, a countdown of phase-comparison cycles runs to 3 + 4·code for a 4-bit code. When it finishes, the block asks the register file to clear GO. Fast-lock is always left on a charge-pump event, so the loop filter sees no glitch. A powerdown or counter-reset input drops fast-lock at once and returns the countdown to its load value.

Top module: `fl_gain_ctrl`

## Requirements
- R1: With `fl_en` low, `fl_oe` is 1, `fl_lvl` equals `fl_ctl`, `cp_x4` equals `go_bit` (0 = low current, 1 = high current) and `div_quarter` is 0, all combinationally.
- R2: With `fl_en` high and `hold` low, a GO bit of 1 makes `cp_x4` 1, `fl_oe` 1 and `fl_lvl` 0 from the clock edge after GO is seen.
- R3: While fast-lock is engaged, `div_quarter` equals `fl_ctl`: 1 selects quarter divide ratios and 0 leaves the ratios unchanged.
- R4: With `fl_en` high and fast-lock not engaged, `fl_oe`, `cp_x4` and `div_quarter` are all 0, so the pin is high impedance.
- R5: With `fl_en` and `tmo_en` high, `go_clr` pulses for exactly one cycle on the edge after the (3 + 4·`tmo_code`)-th `cmp_strobe` that follows a GO write of 1. Bit 0 of the code weighs 4 cycles, code 0 gives 3 cycles and code 15 gives 63.
- R6: With `tmo_en` low, `go_clr` never pulses, and fast-lock stays engaged until GO is written to 0.
- R7: Once GO drops, an engaged fast-lock state is kept until the first clock edge at which `cp_event` is high, and it is released at that edge.
- R8: `hold` high disengages fast-lock on the next edge and puts the countdown back to its full load value. If GO is still set when `hold` is released, fast-lock engages again and the full countdown starts over.
- R9: Writing GO to 1 again while a timed countdown runs restarts the countdown at its full length, using the current code.
- R10: After reset, fast-lock is not engaged and `go_clr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fl_en | input | 1 | Fast-lock enable field |
| fl_ctl | input | 1 | Control field: pin level when disabled, quarter-divide select when enabled |
| tmo_en | input | 1 | Timeout enable field |
| tmo_code | input | 4 | Timeout length code |
| go_bit | input | 1 | Current GO bit from the feedback word |
| go_wr | input | 1 | One-cycle pulse when the feedback word is written |
| cmp_strobe | input | 1 | One pulse per phase-comparison cycle |
| cp_event | input | 1 | Charge-pump event strobe |
| hold | input | 1 | Powerdown or counter reset |
| cp_x4 | output | 1 | Pump current select: 1 selects four times the base current |
| div_quarter | output | 1 | Divide ratios reduced to a quarter |
| fl_lvl | output | 1 | Fast-lock pin level |
| fl_oe | output | 1 | Fast-lock pin drive enable |
| go_clr | output | 1 | Request to clear GO in the register file |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `go_bit` changes only together with a `go_wr` pulse, or after a `go_clr` pulse once the register file has acted on it. The stimulus keeps to this: it drives every input on the falling edge, it models the register file by clearing GO right after it samples `go_clr`, and it keeps the mode fields steady while fast-lock is engaged. `cp_event`, `cmp_strobe` and `hold` are given as separate one-cycle pulses, so the checks can tell the exit edge apart from the expiry edge.

// File: rtl/fl_gain_pkg.sv
package fl_gain_pkg;

    // operating mode decoded from enable / control / timeout fields
    typedef enum logic [2:0] {
        FLM_DIRECT     = 3'd0,
        FLM_WIDE_HOLD  = 3'd1,
        FLM_WIDE_TIMED = 3'd2,
        FLM_DEEP_HOLD  = 3'd3,
        FLM_DEEP_TIMED = 3'd4
    } fl_mode_e;

    typedef struct packed {
        logic direct;
        logic timed;
        logic deep;
    } fl_flags_t;

    typedef struct packed {
        logic cp_x4;
        logic div_quarter;
        logic lvl;
        logic oe;
    } fl_drive_t;

endpackage

// File: rtl/fl_mode_decode.sv
module fl_mode_decode
    import fl_gain_pkg::*;
(
    input  logic      fl_en,
    input  logic      fl_ctl,
    input  logic      tmo_en,
    output fl_flags_t flags
);
    fl_mode_e mode;

    always_comb begin
        if (!fl_en)
            mode = FLM_DIRECT;
        else begin
            case ({fl_ctl, tmo_en})
                2'b00:   mode = FLM_WIDE_HOLD;
                2'b01:   mode = FLM_WIDE_TIMED;
                2'b10:   mode = FLM_DEEP_HOLD;
                default: mode = FLM_DEEP_TIMED;
            endcase
        end
    end

    always_comb begin
        flags = '0;
        case (mode)
            FLM_DIRECT:     flags.direct = 1'b1;
            FLM_WIDE_TIMED: flags.timed  = 1'b1;
            FLM_DEEP_HOLD:  flags.deep   = 1'b1;
            FLM_DEEP_TIMED: begin
                flags.deep  = 1'b1;
                flags.timed = 1'b1;
            end
            default:        flags = '0;
        endcase
    end
endmodule

// File: rtl/fl_timeout.sv
module fl_timeout #(
    parameter int CODE_W = 4,
    parameter int BASE   = 3,
    parameter int STEP   = 4,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic              hold,
    input  logic              reload,
    input  logic              cmp_strobe,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             clr;
    } tmo_state_t;

    tmo_state_t s_d, s_q;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(BASE) + CNT_W'(STEP) * CNT_W'(code);

    always_comb begin
        s_d     = s_q;
        s_d.clr = 1'b0;
        if (hold || reload || !armed) begin
            s_d.cnt  = load_val;
            s_d.done = 1'b0;
        end else if (cmp_strobe && !s_q.done) begin
            if (s_q.cnt <= CNT_W'(1)) begin
                s_d.done = 1'b1;
                s_d.clr  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt  <= CNT_W'(BASE);
            s_q.done <= 1'b0;
            s_q.clr  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign expire = s_q.clr;
endmodule

// File: rtl/fl_exit_sync.sv
module fl_exit_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic hold,
    input  logic cp_event,
    output logic active
);
    logic act_d, act_q;

    always_comb begin
        act_d = act_q;
        if (hold)
            act_d = 1'b0;
        else if (want)
            act_d = 1'b1;
        else if (cp_event)
            act_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act_d;
    end

    assign active = act_q;
endmodule

// File: rtl/fl_gain_ctrl.sv
module fl_gain_ctrl
    import fl_gain_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int BASE   = 3,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_en,
    input  logic              fl_ctl,
    input  logic              tmo_en,
    input  logic [CODE_W-1:0] tmo_code,
    input  logic              go_bit,
    input  logic              go_wr,
    input  logic              cmp_strobe,
    input  logic              cp_event,
    input  logic              hold,
    output logic              cp_x4,
    output logic              div_quarter,
    output logic              fl_lvl,
    output logic              fl_oe,
    output logic              go_clr
);
    localparam int MAX_LEN = BASE + STEP * ((1 << CODE_W) - 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    fl_flags_t flags;
    fl_drive_t drv;
    logic      engaged;
    logic      want;

    fl_mode_decode u_dec (
        .fl_en  (fl_en),
        .fl_ctl (fl_ctl),
        .tmo_en (tmo_en),
        .flags  (flags)
    );

    assign want = !flags.direct && go_bit && !hold;

    fl_timeout #(
        .CODE_W (CODE_W),
        .BASE   (BASE),
        .STEP   (STEP),
        .CNT_W  (CNT_W)
    ) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .armed      (flags.timed && go_bit),
        .hold       (hold),
        .reload     (go_wr && go_bit),
        .cmp_strobe (cmp_strobe),
        .code       (tmo_code),
        .expire     (go_clr)
    );

    fl_exit_sync u_exit (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (want),
        .hold     (hold),
        .cp_event (cp_event),
        .active   (engaged)
    );

    always_comb begin
        drv = '0;
        if (flags.direct) begin
            drv.oe    = 1'b1;
            drv.lvl   = fl_ctl;
            drv.cp_x4 = go_bit;
        end else if (engaged) begin
            drv.oe          = 1'b1;
            drv.lvl         = 1'b0;
            drv.cp_x4       = 1'b1;
            drv.div_quarter = flags.deep;
        end
    end

    assign cp_x4       = drv.cp_x4;
    assign div_quarter = drv.div_quarter;
    assign fl_lvl      = drv.lvl;
    assign fl_oe       = drv.oe;
endmodule

// File: rtl/fl_gain_chk.sv
module fl_gain_chk (
    input logic clk,
    input logic rst_n,
    input logic fl_en,
    input logic fl_ctl,
    input logic tmo_en,
    input logic go_bit,
    input logic cmp_strobe,
    input logic cp_event,
    input logic hold,
    input logic cp_x4,
    input logic div_quarter,
    input logic fl_lvl,
    input logic fl_oe,
    input logic go_clr
);
    // R1
    direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_en |-> (fl_oe && fl_lvl == fl_ctl && cp_x4 == go_bit && !div_quarter));

    // R2
    engaged_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && cp_x4) |-> (fl_oe && !fl_lvl));

    // R3
    quarter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_quarter |-> (fl_en && fl_ctl && cp_x4));

    // R4
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !cp_x4) |-> (!fl_oe && !div_quarter));

    // R5
    clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_clr |-> $past(fl_en && tmo_en && go_bit && cmp_strobe && !hold));

    // R5
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_clr |=> !go_clr);

    // R7
    exit_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && $past(fl_en) && $past(cp_x4) && !cp_x4) |-> $past(cp_event || hold));

    // R8
    hold_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold) && fl_en) |-> !cp_x4);
endmodule

bind fl_gain_ctrl fl_gain_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fl_en       (fl_en),
    .fl_ctl      (fl_ctl),
    .tmo_en      (tmo_en),
    .go_bit      (go_bit),
    .cmp_strobe  (cmp_strobe),
    .cp_event    (cp_event),
    .hold        (hold),
    .cp_x4       (cp_x4),
    .div_quarter (div_quarter),
    .fl_lvl      (fl_lvl),
    .fl_oe       (fl_oe),
    .go_clr      (go_clr)
);

// File: tb/fl_gain_ctrl_test.sv
module fl_gain_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fl_en = 1'b0, fl_ctl = 1'b0, tmo_en = 1'b0;
    logic [3:0] tmo_code = 4'd0;
    logic       go_bit = 1'b0, go_wr = 1'b0;
    logic       cmp_strobe = 1'b0, cp_event = 1'b0, hold = 1'b0;
    logic       cp_x4, div_quarter, fl_lvl, fl_oe, go_clr;

    int checks = 0;
    int errors = 0;
    logic clr_seen;

    always #5 clk = ~clk;

    fl_gain_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fl_en(fl_en), .fl_ctl(fl_ctl),
        .tmo_en(tmo_en), .tmo_code(tmo_code), .go_bit(go_bit), .go_wr(go_wr),
        .cmp_strobe(cmp_strobe), .cp_event(cp_event), .hold(hold),
        .cp_x4(cp_x4), .div_quarter(div_quarter), .fl_lvl(fl_lvl),
        .fl_oe(fl_oe), .go_clr(go_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_go(input logic v);
        go_bit = v;
        go_wr  = 1'b1;
        @(negedge clk);
        go_wr  = 1'b0;
    endtask

    // one comparison strobe; models register-file clear on go_clr
    task automatic strobe();
        cmp_strobe = 1'b1;
        @(negedge clk);
        cmp_strobe = 1'b0;
        clr_seen = go_clr;
        if (go_clr) go_bit = 1'b0;
    endtask

    task automatic cp_pulse();
        cp_event = 1'b1;
        @(negedge clk);
        cp_event = 1'b0;
    endtask

    task automatic t_reset();
        fl_en = 1'b1;
        @(negedge clk);
        chk("R10 engaged after reset", cp_x4, 0);
        chk("R10 go_clr after reset", go_clr, 0);
        chk("R4 pin hi-Z idle", fl_oe, 0);
    endtask

    task automatic t_direct();
        fl_en = 1'b0; fl_ctl = 1'b1; go_bit = 1'b0;
        #1;
        chk("R1 pin level ctl=1", fl_lvl, 1);
        chk("R1 pin enabled", fl_oe, 1);
        chk("R1 current low", cp_x4, 0);
        fl_ctl = 1'b0; go_bit = 1'b1;
        #1;
        chk("R1 pin level ctl=0", fl_lvl, 0);
        chk("R1 current high", cp_x4, 1);
        chk("R1 no quarter", div_quarter, 0);
        go_bit = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_untimed(input logic ctl);
        int clrs = 0;
        fl_en = 1'b1; fl_ctl = ctl; tmo_en = 1'b0; tmo_code = 4'd0;
        @(negedge clk);
        chk("R4 idle current", cp_x4, 0);
        write_go(1'b1);
        chk("R2 4x engaged", cp_x4, 1);
        chk("R2 pin driven", fl_oe, 1);
        chk("R2 pin low", fl_lvl, 0);
        chk("R3 quarter follows ctl", div_quarter, int'(ctl));
        for (int i = 0; i < 80; i++) begin
            strobe();
            if (clr_seen) clrs++;
        end
        chk("R6 no go_clr untimed", clrs, 0);
        chk("R6 still engaged", cp_x4, 1);
        write_go(1'b0);
        repeat (3) @(negedge clk);
        chk("R7 held until cp event", cp_x4, 1);
        cp_pulse();
        chk("R7 released on cp event", cp_x4, 0);
        chk("R4 pin hi-Z after exit", fl_oe, 0);
        chk("R4 no quarter after exit", div_quarter, 0);
    endtask

    task automatic t_timeout(input logic [3:0] code, input int exp_len);
        int n = 0;
        fl_en = 1'b1; fl_ctl = 1'b0; tmo_en = 1'b1; tmo_code = code;
        @(negedge clk);
        write_go(1'b1);
        chk("R2 timed engaged", cp_x4, 1);
        for (int i = 0; i < 70; i++) begin
            strobe();
            n++;
            if (clr_seen) break;
        end
        chk("R5 timeout length", n, exp_len);
        @(negedge clk);
        chk("R5 go_clr single cycle", go_clr, 0);
        chk("R7 held after expiry", cp_x4, 1);
        cp_pulse();
        chk("R7 released after expiry", cp_x4, 0);
    endtask

    task automatic t_reload();
        int n = 0;
        fl_en = 1'b1; fl_ctl = 1'b1; tmo_en = 1'b1; tmo_code = 4'd0;
        @(negedge clk);
        write_go(1'b1);
        strobe(); strobe();
        chk("R9 no clear before reload", int'(clr_seen), 0);
        write_go(1'b1);
        for (int i = 0; i < 10; i++) begin
            strobe();
            n++;
            if (clr_seen) break;
        end
        chk("R9 full length after reload", n, 3);
        cp_pulse();
        chk("R7 exit after reload test", cp_x4, 0);
    endtask

    task automatic t_hold();
        int n = 0;
        fl_en = 1'b1; fl_ctl = 1'b0; tmo_en = 1'b1; tmo_code = 4'd1;
        @(negedge clk);
        write_go(1'b1);
        repeat (5) strobe();
        hold = 1'b1;
        @(negedge clk);
        chk("R8 hold drops 4x", cp_x4, 0);
        chk("R8 hold pin hi-Z", fl_oe, 0);
        strobe();
        chk("R8 strobe ignored in hold", int'(clr_seen), 0);
        hold = 1'b0;
        @(negedge clk);
        chk("R8 re-engaged after hold", cp_x4, 1);
        for (int i = 0; i < 20; i++) begin
            strobe();
            n++;
            if (clr_seen) break;
        end
        chk("R8 full count after hold", n, 7);
        cp_pulse();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_untimed(1'b0);
        t_untimed(1'b1);
        t_timeout(4'd6, 27);
        t_timeout(4'd0, 3);
        t_timeout(4'd15, 63);
        t_reload();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule